// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block is a bus-master DMA engine that sits between a disk device data port and system memory. Software programs a descriptor-table pointer and a direction through a small register window, then sets a start bit. The engine walks the memory-resident table one descriptor at a time. Each descriptor names a buffer address and a byte count. For every byte the engine performs one source read and one destination write, stepping through consecutive buffer addresses. It stops after the descriptor marked as final, when software clears the start bit, or when memory reports a fault.

Completion is signalled by a sticky interrupt flag, which also drives the `irq` output. A memory fault sets a sticky error flag. Software clears both flags by writing ones to them. The status register also holds two software-owned flags that mark which attached drives may use DMA. Memory and device are reached through simple request/acknowledge ports. A request is held, with its address and data stable, until it is acknowledged.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and neither `mem_req` nor `dev_req` is asserted.
- R2: The register window is selected by `reg_addr`. Offset 0 is the command register: bit 0 is start and bit 1 is direction. Offset 2 is the status register: bit 0 is active, bit 1 is error, bit 2 is interrupt, and bits 5 and 6 are the drive flags. Offset 4 is the table pointer, which reads back with its two low bits forced to 0. The command register reads back as written.
- R3: Each descriptor is two 32-bit little-endian words, fetched from the table pointer upward. The first word is the buffer address. In the second word, the low LEN_W bits hold the byte count and bit 31 marks the last descriptor. The next descriptor follows 8 bytes later.
- R4: A byte count of 0 moves 2^LEN_W bytes (65536 with default parameters), and no byte beyond that.
- R5: With direction 0, each byte is read from memory (`mem_rdata[7:0]`) and written to the device. With direction 1, each byte is read from the device and written to memory with `mem_we`=1 on `mem_wdata[7:0]`. The memory and device requests are never asserted together.
- R6: Within a descriptor, bytes move in order at consecutive memory addresses starting at the buffer address.
- R7: When the final byte of the last descriptor is written, active clears, interrupt sets, `irq` rises and requests stop.
- R8: Writing the command register with start = 0 during a transfer removes all requests right after that write. Active clears and interrupt stays 0.
- R9: A memory acknowledge with `mem_err` high sets error, clears active and halts the engine. Interrupt is not set.
- R10: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R11: Status bits 5 and 6 take the value of every status write and are never changed by the engine.
- R12: A transfer starts only when start goes from 0 to 1. Writing start = 1 while it is already 1 starts nothing.
- R13: A request that is not acknowledged stays asserted with a stable address in the next cycle, unless start has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a byte write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data, byte on bits 7:0 |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory fault, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| dev_req | output | 1 | Device data port request |
| dev_we | output | 1 | Device access is a write to the device |
| dev_wdata | output | 8 | Byte to the device |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 8 | Byte from the device, valid with `dev_ack` |
| irq | output | 1 | Interrupt flag |

## Verification
The embedded properties are checked on every cycle. They cover the request handshake: a pending request keeps its address, memory and device are never requested together, descriptor fetches are word aligned, and nothing is requested while inactive. They also check that a rising interrupt or error flag always coincides with active being low. Only the bench scenarios can show that the moved byte streams match the buffers the descriptors name. The same holds for a zero count giving exactly 2^LEN_W bytes, for the point at which stop or a fault cuts a stream, and for the write-one-to-clear and drive-flag behaviour seen through register reads.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   // register window offsets
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_TBL  = 3'd4;

   // command bits
   localparam int CMD_GO  = 0;
   localparam int CMD_DIR = 1;

   // status bits
   localparam int ST_ACT  = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_INT  = 2;
   localparam int ST_DRVA = 5;
   localparam int ST_DRVB = 6;

   // descriptor end-of-table marker in second word
   localparam int DESC_END = 31;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DADDR,
      SQ_DLEN,
      SQ_SRC,
      SQ_DST
   } seq_state_t;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              run_o,
   output logic              go_o,
   output logic              go_dir_o,
   output logic [ADDR_W-1:0] tbl_o,
   input  logic              seq_done,
   input  logic              seq_fault,
   output logic              act_o,
   output logic              irq_o
);
   logic              start_q, dir_q, act_q, err_q, intr_q;
   logic [1:0]        drv_q;
   logic [ADDR_W-1:0] tbl_q;
   logic              cmd_wr, stat_wr, tbl_wr;

   assign cmd_wr  = reg_we && (reg_addr == OFS_CMD);
   assign stat_wr = reg_we && (reg_addr == OFS_STAT);
   assign tbl_wr  = reg_we && (reg_addr == OFS_TBL);

   assign go_o     = cmd_wr && reg_wdata[CMD_GO] && !start_q;
   assign go_dir_o = reg_wdata[CMD_DIR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         dir_q   <= 1'b0;
         act_q   <= 1'b0;
         err_q   <= 1'b0;
         intr_q  <= 1'b0;
         drv_q   <= '0;
         tbl_q   <= '0;
      end else begin
         if (cmd_wr) begin
            start_q <= reg_wdata[CMD_GO];
            dir_q   <= reg_wdata[CMD_DIR];
         end
         if (go_o)
            act_q <= 1'b1;
         else if (seq_done || seq_fault || (cmd_wr && !reg_wdata[CMD_GO]))
            act_q <= 1'b0;
         if (seq_fault)
            err_q <= 1'b1;
         else if (stat_wr && reg_wdata[ST_ERR])
            err_q <= 1'b0;
         if (seq_done)
            intr_q <= 1'b1;
         else if (stat_wr && reg_wdata[ST_INT])
            intr_q <= 1'b0;
         if (stat_wr)
            drv_q <= reg_wdata[ST_DRVB:ST_DRVA];
         if (tbl_wr)
            tbl_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CMD:  reg_rdata = {30'd0, dir_q, start_q};
         OFS_STAT: reg_rdata = {25'd0, drv_q, 2'b00, intr_q, err_q, act_q};
         OFS_TBL:  reg_rdata[ADDR_W-1:0] = tbl_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign run_o = start_q;
   assign tbl_o = tbl_q;
   assign act_o = act_q;
   assign irq_o = intr_q;

   // R7
   int_rise_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_q) |-> !act_q);
   // R9
   err_rise_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> !act_q && !$rose(intr_q));
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              go,
   input  logic              go_dir,
   input  logic [ADDR_W-1:0] tbl,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [31:0]       mem_rdata,
   output logic              dev_req,
   output logic              dev_we,
   output logic [7:0]        dev_wdata,
   input  logic              dev_ack,
   input  logic [7:0]        dev_rdata,
   output logic              done,
   output logic              fault
);
   localparam int CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << LEN_W;
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $fatal(1, "LEN_W must lie in 1..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $fatal(1, "ADDR_W must lie in 8..32");
      end
   endgenerate

   seq_state_t        state_q;
   logic [ADDR_W-1:0] dptr_q, baddr_q;
   logic [CNT_W-1:0]  remain_q;
   logic              last_q, dir_q;
   logic [7:0]        data_q;
   logic              fetching, step;
   logic [LEN_W-1:0]  len_field;
   logic              unused_rdata;

   assign fetching  = (state_q == SQ_DADDR) || (state_q == SQ_DLEN);
   assign len_field = mem_rdata[LEN_W-1:0];
   assign unused_rdata = ^mem_rdata[30:LEN_W];

   assign mem_req   = run && (fetching || (state_q == SQ_SRC && !dir_q) ||
                              (state_q == SQ_DST && dir_q));
   assign mem_we    = (state_q == SQ_DST);
   assign mem_addr  = fetching ? dptr_q : baddr_q;
   assign mem_wdata = {24'd0, data_q};
   assign dev_req   = run && ((state_q == SQ_SRC && dir_q) ||
                              (state_q == SQ_DST && !dir_q));
   assign dev_we    = (state_q == SQ_DST);
   assign dev_wdata = data_q;

   assign fault = mem_req && mem_ack && mem_err;
   assign step  = (mem_req && mem_ack && !mem_err) || (dev_req && dev_ack);
   assign done  = step && (state_q == SQ_DST) && (remain_q == ONE_CNT) && last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         dptr_q   <= '0;
         baddr_q  <= '0;
         remain_q <= '0;
         last_q   <= 1'b0;
         dir_q    <= 1'b0;
         data_q   <= '0;
      end else if (go) begin
         state_q <= SQ_DADDR;
         dptr_q  <= tbl;
         dir_q   <= go_dir;
      end else if (state_q != SQ_IDLE && (!run || fault)) begin
         state_q <= SQ_IDLE;
      end else if (step) begin
         unique case (state_q)
            SQ_DADDR: begin
               baddr_q <= mem_rdata[ADDR_W-1:0];
               dptr_q  <= dptr_q + ADDR_W'(4);
               state_q <= SQ_DLEN;
            end
            SQ_DLEN: begin
               remain_q <= (len_field == '0) ? FULL_CNT : CNT_W'(len_field);
               last_q   <= mem_rdata[DESC_END];
               dptr_q   <= dptr_q + ADDR_W'(4);
               state_q  <= SQ_SRC;
            end
            SQ_SRC: begin
               data_q  <= dir_q ? dev_rdata : mem_rdata[7:0];
               state_q <= SQ_DST;
            end
            SQ_DST: begin
               baddr_q  <= baddr_q + ADDR_W'(1);
               remain_q <= remain_q - ONE_CNT;
               if (remain_q == ONE_CNT)
                  state_q <= last_q ? SQ_IDLE : SQ_DADDR;
               else
                  state_q <= SQ_SRC;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R13
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> !run || (mem_req && $stable(mem_addr)));
   // R13
   dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && !dev_ack |=> !run || (dev_req && $stable(dev_we)));
   // R5
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && dev_req));
   // R3
   desc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && fetching |-> mem_addr[1:0] == 2'b00);
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [31:0]       mem_rdata,
   output logic              dev_req,
   output logic              dev_we,
   output logic [7:0]        dev_wdata,
   input  logic              dev_ack,
   input  logic [7:0]        dev_rdata,
   output logic              irq
);
   logic              run, go, go_dir, done, fault, act;
   logic [ADDR_W-1:0] tbl;

   bmdma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .run_o(run), .go_o(go), .go_dir_o(go_dir), .tbl_o(tbl),
      .seq_done(done), .seq_fault(fault),
      .act_o(act), .irq_o(irq)
   );

   bmdma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .run(run), .go(go), .go_dir(go_dir), .tbl(tbl),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata),
      .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata),
      .dev_ack(dev_ack), .dev_rdata(dev_rdata),
      .done(done), .fault(fault)
   );

   // R8
   quiet_when_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !mem_req && !dev_req);
endmodule

// File: tb/sim_bmdma_engine.sv
module sim_bmdma_engine;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        dev_req, dev_we;
   logic [7:0]  dev_wdata;
   logic        dev_ack = 1'b0;
   logic [7:0]  dev_rdata = '0;
   logic        irq;

   int checks = 0, fails = 0;
   logic [7:0] mem8 [0:4095];
   logic [7:0] dev_log [0:4095];
   int dev_wr_cnt = 0, dev_rd_cnt = 0;
   logic err_en = 1'b0;
   logic [31:0] err_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmdma_engine #(.ADDR_W(32), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata),
      .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata),
      .dev_ack(dev_ack), .dev_rdata(dev_rdata), .irq(irq)
   );

   function automatic logic [7:0] dev_pat(input int k);
      return 8'((k * 37 + 11) ^ (k >> 3));
   endfunction

   // memory and device responders, random wait states
   always @(negedge clk) begin
      mem_ack = mem_req && ($urandom % 3 != 0);
      mem_err = mem_ack && err_en && (mem_addr == err_addr);
      if (mem_ack && !mem_err) begin
         if (mem_we) mem8[mem_addr[11:0]] = mem_wdata[7:0];
         else mem_rdata = {mem8[12'(mem_addr + 3)], mem8[12'(mem_addr + 2)],
                           mem8[12'(mem_addr + 1)], mem8[mem_addr[11:0]]};
      end
      dev_ack = dev_req && ($urandom % 3 != 0);
      if (dev_ack) begin
         if (dev_we) begin
            dev_log[dev_wr_cnt % 4096] = dev_wdata;
            dev_wr_cnt++;
         end else begin
            dev_rdata = dev_pat(dev_rd_cnt);
            dev_rd_cnt++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_word(input int a, input logic [31:0] w);
      for (int i = 0; i < 4; i++) mem8[(a + i) % 4096] = w[8*i +: 8];
   endtask

   task automatic put_desc(input int tbl, input int idx, input int buf_a,
                           input int len, input bit last);
      put_word(tbl + 8*idx, 32'(buf_a));
      put_word(tbl + 8*idx + 4, {last, 15'd0, 16'(len)});
   endtask

   task automatic launch(input int tbl, input bit dir);
      wr(3'd0, {30'd0, dir, 1'b0});
      wr(3'd2, 32'h6);
      wr(3'd4, 32'(tbl));
      wr(3'd0, {30'd0, dir, 1'b1});
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 20000) begin @(negedge clk); n++; end
      chk(req, {31'd0, irq}, 32'd1);
   endtask

   logic [31:0] r;
   int base_w, base_r, bad;
   int ndesc, tot, exp_b;
   int lens [0:2];
   bit dirs;

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < 4096; i++) mem8[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, r); chk("R1 cmd", r, 0);
      rd(3'd2, r); chk("R1 status", r, 0);
      rd(3'd4, r); chk("R1 table", r, 0);
      chk("R1 idle", {29'd0, irq, mem_req, dev_req}, 0);
      rst_n = 1'b1;
      // R2 register readback
      wr(3'd4, 32'h1234_5677); rd(3'd4, r); chk("R2 table align", r, 32'h1234_5674);
      wr(3'd0, 32'h2); rd(3'd0, r); chk("R2 cmd", r, 32'h2);
      chk("R2 no start", {30'd0, mem_req, dev_req}, 0);

      // R3 R5 R6 R7 memory to device, two descriptors
      put_desc(32'h100, 0, 32'h200, 5, 1'b0);
      put_desc(32'h100, 1, 32'h300, 3, 1'b1);
      base_w = dev_wr_cnt;
      launch(32'h100, 1'b0);
      wait_irq("R7 irq");
      repeat (4) @(negedge clk);
      chk("R3 byte count", 32'(dev_wr_cnt - base_w), 8);
      bad = 0;
      for (int i = 0; i < 8; i++)
         if (dev_log[(base_w + i) % 4096] !== mem8[i < 5 ? 32'h200 + i : 32'h300 + i - 5]) bad++;
      chk("R6 data order", 32'(bad), 0);
      rd(3'd2, r); chk("R7 status done", r, 32'h4);
      chk("R7 quiet", {30'd0, mem_req, dev_req}, 0);
      // R12 start already set: no restart
      wr(3'd0, 32'h1);
      repeat (20) @(negedge clk);
      chk("R12 no restart", 32'(dev_wr_cnt - base_w), 8);
      rd(3'd2, r); chk("R12 status", r, 32'h4);
      // R10 R11 write-one-to-clear and drive flags
      wr(3'd2, 32'h60); rd(3'd2, r); chk("R10 zero keeps", r, 32'h64);
      wr(3'd2, 32'h24); rd(3'd2, r); chk("R11 flags", r, 32'h20);
      wr(3'd2, 32'h00); rd(3'd2, r); chk("R11 flags clear", r, 32'h0);

      // R4 zero length, device to memory
      mem8[32'h500] = 8'hA5;
      put_desc(32'h140, 0, 32'h400, 0, 1'b1);
      base_r = dev_rd_cnt;
      launch(32'h140, 1'b1);
      wait_irq("R4 irq");
      repeat (4) @(negedge clk);
      chk("R4 reads", 32'(dev_rd_cnt - base_r), 32'd1 << LEN_W);
      bad = 0;
      for (int i = 0; i < (1 << LEN_W); i++)
         if (mem8[32'h400 + i] !== dev_pat(base_r + i)) bad++;
      chk("R5 dev to mem data", 32'(bad), 0);
      chk("R4 no overrun", {24'd0, mem8[32'h500]}, 32'hA5);

      // random descriptor chains, both directions
      for (int it = 0; it < 6; it++) begin
         ndesc = 1 + $urandom % 3;
         dirs = 1'($urandom);
         tot = 0;
         for (int d = 0; d < ndesc; d++) begin
            lens[d] = 1 + $urandom % 24;
            put_desc(32'h40, d, 32'h800 + 32'h80 * d, lens[d], d == ndesc - 1);
            tot += lens[d];
         end
         base_w = dev_wr_cnt; base_r = dev_rd_cnt;
         launch(32'h40, dirs);
         wait_irq("R7 random irq");
         repeat (4) @(negedge clk);
         bad = 0; exp_b = 0;
         for (int d = 0; d < ndesc; d++)
            for (int i = 0; i < lens[d]; i++) begin
               if (dirs) begin
                  if (mem8[32'h800 + 32'h80 * d + i] !== dev_pat(base_r + exp_b)) bad++;
               end else begin
                  if (dev_log[(base_w + exp_b) % 4096] !== mem8[32'h800 + 32'h80 * d + i]) bad++;
               end
               exp_b++;
            end
         chk("R3 random count", 32'(dirs ? dev_rd_cnt - base_r : dev_wr_cnt - base_w), 32'(tot));
         chk("R5 random data", 32'(bad), 0);
         rd(3'd2, r); chk("R7 random status", r, 32'h4);
      end

      // R8 stop mid transfer
      put_desc(32'h180, 0, 32'h200, 200, 1'b1);
      base_w = dev_wr_cnt;
      launch(32'h180, 1'b0);
      while (dev_wr_cnt - base_w < 10) @(negedge clk);
      wr(3'd0, 32'h0);
      chk("R8 quiet", {30'd0, mem_req, dev_req}, 0);
      tot = dev_wr_cnt;
      repeat (20) @(negedge clk);
      chk("R8 halted", 32'(dev_wr_cnt), 32'(tot));
      rd(3'd2, r); chk("R8 status", r, 32'h0);

      // R9 memory fault
      put_desc(32'h1C0, 0, 32'h600, 10, 1'b1);
      err_en = 1'b1; err_addr = 32'h605;
      base_w = dev_wr_cnt;
      launch(32'h1C0, 1'b0);
      repeat (200) @(negedge clk);
      err_en = 1'b0;
      rd(3'd2, r); chk("R9 status", r, 32'h2);
      chk("R9 stopped", 32'(dev_wr_cnt - base_w), 5);
      chk("R9 quiet", {30'd0, mem_req, dev_req}, 0);
      wr(3'd2, 32'h2); rd(3'd2, r); chk("R10 err clear", r, 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule